// File: doc/BRIEF.md
# Processor-side interrupt interface

This block is the per-processor stage between an interrupt distributor and one processor core. Each cycle the distributor offers its best candidate as an ID, a priority and a valid flag, together with its own global enable. The block filters that candidate against a software priority mask, a local enable bit and the priority of the interrupt now being serviced. When the candidate passes, the block raises the request line to the core. Lower numeric priority values are more urgent.

Software works through a small register port. An acknowledge read claims the qualifying candidate and marks it active. A completion write returns the claimed value and retires it. Active interrupts are kept on a stack of `NEST_DEPTH` entries, so a more urgent interrupt can pre-empt one in service. A one-cycle claim pulse and a one-cycle completion pulse tell the distributor when to move an interrupt's state.

The register port has no back-pressure: a request is accepted in the cycle it is presented. A read returns data with a response strobe in the following cycle. Writes return nothing. The distributor candidate inputs and the pulse outputs are plain level and strobe signals, with no handshake.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low, the local enable is 0, the priority mask is 0x00, the running priority reads 0xFF, no interrupt is active and neither pulse output is high.
- R2: Offset 0x00 holds the local enable in bit 0 (read/write, other bits read 0). Offset 0x04 holds the priority mask in bits [7:0] (read/write, other bits read 0). Offset 0x08 always reads 0 and writes to it have no effect.
- R3: The request line is high exactly when all of the following are true: the local enable is 1; the distributor enable is 1; the candidate is valid; its ID is below 1020; its priority is strictly below the mask; its priority is strictly below the running priority; and the active stack is not full.
- R4: A read of offset 0x0C while the request line is high returns the candidate ID in bits [9:0] and zero above. In the response cycle it raises the claim pulse with that ID for exactly one cycle. The running priority becomes the candidate's priority.
- R5: A read of offset 0x0C while the request line is low returns 1023, gives no claim pulse and leaves the running priority unchanged.
- R6: Candidate IDs 1020 to 1023 never raise the request line and are never claimed.
- R7: A write to offset 0x10 whose whole data word equals the ID of the most recently claimed active interrupt retires that interrupt. In the next cycle it raises the completion pulse with that ID for one cycle. The running priority returns to the priority of the previous active entry, or to 0xFF when none is left.
- R8: A write to offset 0x10 with any other value, or with nothing active, is ignored: there is no completion pulse and the running priority is unchanged.
- R9: Up to `NEST_DEPTH` interrupts can be active at once, each claimed one more urgent than the last. While the stack is full the request line stays low and acknowledge reads return 1023.
- R10: Offset 0x14 reads the running priority in bits [7:0]. Offset 0x18 reads the candidate ID when the candidate is valid and below 1020, and 1023 otherwise. Both are read-only, and writes to them change nothing.
- R11: Every read raises the response strobe in the following cycle with its data. Writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, accepted in the same cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rsp_valid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 32 | Read data |
| dist_en | input | 1 | Distributor global enable |
| cand_valid | input | 1 | Distributor candidate present |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle claim strobe to the distributor |
| ack_id | output | 10 | ID claimed |
| eoi_pulse | output | 1 | One-cycle completion strobe to the distributor |
| eoi_id | output | 10 | ID completed |

## Verification
Some properties are checked on every cycle. A claim never carries a reserved ID, and its strobe always coincides with response data carrying the same ID. Each new active entry is strictly more urgent than the one it pre-empts, and the running priority follows the last claim. A completion always names the interrupt that was on top of the stack. The two strobes never coincide, and responses only follow reads. The bench scenarios cover the rest: the full gating truth table of the request line, the equal-priority boundaries, nested claim and unwind order, mismatched and stray completions, the full-stack cut-off, and the read-only and read-as-zero registers.

// File: rtl/irq_if_pkg.sv
package irq_if_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ID_W-1:0] SPURIOUS_ID    = 10'd1023;
  localparam logic [ID_W-1:0] FIRST_RESERVED = 10'd1020;

  typedef enum logic [7:0] {
    OFF_CTRL = 8'h00,
    OFF_MASK = 8'h04,
    OFF_BP   = 8'h08,
    OFF_ACK  = 8'h0C,
    OFF_EOI  = 8'h10,
    OFF_RUN  = 8'h14,
    OFF_HIGH = 8'h18
  } reg_off_e;
endpackage

// File: rtl/cpu_if_gate.sv
module cpu_if_gate
  import irq_if_pkg::*;
#(
  parameter int IDW = ID_W,
  parameter int PW  = PRIO_W
) (
  input  logic          if_en,
  input  logic          dist_en,
  input  logic          cand_valid,
  input  logic [IDW-1:0] cand_id,
  input  logic [PW-1:0]  cand_prio,
  input  logic [PW-1:0]  prio_mask,
  input  logic [PW-1:0]  running_prio,
  input  logic          stack_full,
  output logic          qualify,
  output logic [IDW-1:0] pend_id
);
  logic real_id;
  logic beats_mask;
  logic beats_run;

  always_comb begin
    real_id    = cand_valid && (cand_id < IDW'(FIRST_RESERVED));
    beats_mask = cand_prio < prio_mask;
    beats_run  = cand_prio < running_prio;
    qualify    = if_en && dist_en && real_id && beats_mask && beats_run && !stack_full;
    pend_id    = real_id ? cand_id : IDW'(SPURIOUS_ID);
  end
endmodule

// File: rtl/cpu_if_active_stack.sv
module cpu_if_active_stack
  import irq_if_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDW   = ID_W,
  parameter int PW    = PRIO_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [IDW-1:0] push_id,
  input  logic [PW-1:0]  push_prio,
  input  logic           pop,
  output logic [PW-1:0]  running_prio,
  output logic [IDW-1:0] top_id,
  output logic           nonempty,
  output logic           full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDW-1:0] id_mem   [DEPTH];
  logic [PW-1:0]  prio_mem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] top_idx;
  logic [PTR_W-1:0] wr_idx;

  assign nonempty = count != '0;
  assign full     = count == CNT_W'(DEPTH);
  assign top_idx  = PTR_W'(count - CNT_W'(1));
  assign wr_idx   = PTR_W'(count);

  always_comb begin
    running_prio = nonempty ? prio_mem[top_idx] : {PW{1'b1}};
    top_id       = nonempty ? id_mem[top_idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_mem[i]   <= '0;
        prio_mem[i] <= '0;
      end
    end else if (push && !full) begin
      id_mem[wr_idx]   <= push_id;
      prio_mem[wr_idx] <= push_prio;
      count            <= count + CNT_W'(1);
    end else if (pop && nonempty) begin
      count <= count - CNT_W'(1);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R9
  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full |-> push_prio < running_prio); // R3
  AST_PUSH_SETS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full |=> running_prio == $past(push_prio)); // R4
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop && nonempty && !push |=> count == $past(count) - CNT_W'(1)); // R7
endmodule

// File: rtl/cpu_if_regfile.sv
module cpu_if_regfile
  import irq_if_pkg::*;
#(
  parameter int IDW = ID_W,
  parameter int PW  = PRIO_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rdata,
  output logic           if_en,
  output logic [PW-1:0]  prio_mask,
  input  logic           qualify,
  input  logic [IDW-1:0] cand_id,
  input  logic [IDW-1:0] pend_id,
  input  logic [PW-1:0]  running_prio,
  input  logic [IDW-1:0] top_id,
  input  logic           nonempty,
  output logic           push,
  output logic           pop,
  output logic           ack_pulse,
  output logic [IDW-1:0] ack_id,
  output logic           eoi_pulse,
  output logic [IDW-1:0] eoi_id
);
  logic          rd_en;
  logic          wr_en;
  logic [DW-1:0] rd_mux;

  assign rd_en = req && !wr;
  assign wr_en = req && wr;
  assign push  = rd_en && (addr == AW'(OFF_ACK)) && qualify;
  assign pop   = wr_en && (addr == AW'(OFF_EOI)) && nonempty && (wdata == DW'(top_id));

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(OFF_CTRL))      rd_mux = DW'(if_en);
    else if (addr == AW'(OFF_MASK)) rd_mux = DW'(prio_mask);
    else if (addr == AW'(OFF_ACK))  rd_mux = qualify ? DW'(cand_id) : DW'(SPURIOUS_ID);
    else if (addr == AW'(OFF_RUN))  rd_mux = DW'(running_prio);
    else if (addr == AW'(OFF_HIGH)) rd_mux = DW'(pend_id);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rdata     <= '0;
      if_en     <= 1'b0;
      prio_mask <= '0;
      ack_pulse <= 1'b0;
      ack_id    <= '0;
      eoi_pulse <= 1'b0;
      eoi_id    <= '0;
    end else begin
      rsp_valid <= rd_en;
      rdata     <= rd_en ? rd_mux : '0;
      ack_pulse <= push;
      ack_id    <= push ? cand_id : '0;
      eoi_pulse <= pop;
      eoi_id    <= pop ? top_id : '0;
      if (wr_en && addr == AW'(OFF_CTRL)) if_en     <= wdata[0];
      if (wr_en && addr == AW'(OFF_MASK)) prio_mask <= wdata[PW-1:0];
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req && !wr)); // R11
  AST_ACK_REAL_ID: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> ack_id < IDW'(FIRST_RESERVED)); // R6
  AST_ACK_MATCHES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> rsp_valid && rdata == DW'(ack_id)); // R4
  AST_EOI_NAMES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> eoi_id == $past(top_id)); // R7
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_pulse && eoi_pulse)); // R8
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import irq_if_pkg::*;
#(
  parameter int NEST_DEPTH = 4,
  parameter int IDW        = ID_W,
  parameter int PW         = PRIO_W,
  parameter int DW         = DATA_W,
  parameter int AW         = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_req,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic           reg_rsp_valid,
  output logic [DW-1:0]  reg_rdata,
  input  logic           dist_en,
  input  logic           cand_valid,
  input  logic [IDW-1:0] cand_id,
  input  logic [PW-1:0]  cand_prio,
  output logic           irq,
  output logic           ack_pulse,
  output logic [IDW-1:0] ack_id,
  output logic           eoi_pulse,
  output logic [IDW-1:0] eoi_id
);
  logic           if_en;
  logic [PW-1:0]  prio_mask;
  logic [PW-1:0]  running_prio;
  logic [IDW-1:0] top_id;
  logic [IDW-1:0] pend_id;
  logic           nonempty;
  logic           full;
  logic           qualify;
  logic           push;
  logic           pop;

  cpu_if_gate #(.IDW(IDW), .PW(PW)) u_gate (
    .if_en(if_en), .dist_en(dist_en), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_prio(cand_prio), .prio_mask(prio_mask),
    .running_prio(running_prio), .stack_full(full),
    .qualify(qualify), .pend_id(pend_id)
  );

  cpu_if_active_stack #(.DEPTH(NEST_DEPTH), .IDW(IDW), .PW(PW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_id(cand_id),
    .push_prio(cand_prio), .pop(pop), .running_prio(running_prio),
    .top_id(top_id), .nonempty(nonempty), .full(full)
  );

  cpu_if_regfile #(.IDW(IDW), .PW(PW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rsp_valid(reg_rsp_valid), .rdata(reg_rdata),
    .if_en(if_en), .prio_mask(prio_mask), .qualify(qualify),
    .cand_id(cand_id), .pend_id(pend_id), .running_prio(running_prio),
    .top_id(top_id), .nonempty(nonempty), .push(push), .pop(pop),
    .ack_pulse(ack_pulse), .ack_id(ack_id),
    .eoi_pulse(eoi_pulse), .eoi_id(eoi_id)
  );

  assign irq = qualify;

  AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> if_en && dist_en && cand_valid); // R3
  AST_IDLE_AFTER_LAST_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nonempty) |-> running_prio == {PW{1'b1}}); // R7
endmodule

// File: tb/tb_cpu_irq_iface.sv
module tb_cpu_irq_iface;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rsp_valid;
  logic [31:0] reg_rdata;
  logic        dist_en = 1'b0, cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        irq, ack_pulse, eoi_pulse;
  logic [9:0]  ack_id, eoi_id;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  cpu_irq_iface dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rdata(reg_rdata), .dist_en(dist_en), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_prio(cand_prio), .irq(irq),
    .ack_pulse(ack_pulse), .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id)
  );

  // {if_en, dist_en, valid, id[9:0], prio[7:0], mask[7:0], expected irq}
  localparam logic [29:0] VEC [9] = '{
    {1'b1, 1'b1, 1'b1, 10'd40,   8'h20, 8'hFF, 1'b1},
    {1'b0, 1'b1, 1'b1, 10'd40,   8'h20, 8'hFF, 1'b0},
    {1'b1, 1'b0, 1'b1, 10'd40,   8'h20, 8'hFF, 1'b0},
    {1'b1, 1'b1, 1'b0, 10'd40,   8'h20, 8'hFF, 1'b0},
    {1'b1, 1'b1, 1'b1, 10'd41,   8'h30, 8'h30, 1'b0},
    {1'b1, 1'b1, 1'b1, 10'd41,   8'h2F, 8'h30, 1'b1},
    {1'b1, 1'b1, 1'b1, 10'd1020, 8'h10, 8'hFF, 1'b0},
    {1'b1, 1'b1, 1'b1, 10'd1019, 8'hFE, 8'hFF, 1'b1},
    {1'b1, 1'b1, 1'b1, 10'd3,    8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_cand(input logic v, input logic [9:0] id, input logic [7:0] p);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    dist_en = 1'b1;
    set_cand(1'b1, 10'd12, 8'h10);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 ack_pulse", {31'b0, ack_pulse}, 32'd0);
    chk("R1 eoi_pulse", {31'b0, eoi_pulse}, 32'd0);
    reg_read(8'h00, d); chk("R1 enable", d, 32'd0);
    reg_read(8'h04, d); chk("R1 mask", d, 32'd0);
    reg_read(8'h14, d); chk("R1 running", d, 32'h0FF);
    reg_read(8'h0C, d); chk("R1 ack spurious", d, 32'd1023);
    chk("R1 no claim", {31'b0, ack_pulse}, 32'd0);

    // R3/R6: gating table
    for (int i = 0; i < 9; i++) begin
      reg_write(8'h00, {31'b0, VEC[i][29]});
      reg_write(8'h04, {24'b0, VEC[i][8:1]});
      dist_en = VEC[i][28];
      set_cand(VEC[i][27], VEC[i][26:17], VEC[i][16:9]);
      @(negedge clk);
      chk($sformatf("R3 vector %0d", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R2: control, mask and binary-point offsets
    dist_en = 1'b1;
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, d); chk("R2 enable readback", d, 32'd1);
    reg_write(8'h04, 32'h0000_01AB);
    reg_read(8'h04, d); chk("R2 mask readback", d, 32'h0AB);
    reg_write(8'h08, 32'h0000_0007);
    reg_read(8'h08, d); chk("R2 binary point reads zero", d, 32'd0);
    reg_write(8'h04, 32'h0000_00FF);

    // R11: response strobe
    reg_write(8'h04, 32'h0000_00FF);
    chk("R11 no rsp on write", {31'b0, reg_rsp_valid}, 32'd0);
    reg_read(8'h04, d);
    chk("R11 rsp on read", {31'b0, reg_rsp_valid}, 32'd1);

    // R4: claim
    set_cand(1'b1, 10'd45, 8'h40);
    @(negedge clk);
    chk("R4 irq before claim", {31'b0, irq}, 32'd1);
    reg_read(8'h0C, d);
    chk("R4 ack data", d, 32'd45);
    chk("R4 claim pulse", {31'b0, ack_pulse}, 32'd1);
    chk("R4 claim id", {22'b0, ack_id}, 32'd45);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, ack_pulse}, 32'd0);
    reg_read(8'h14, d); chk("R4 running prio", d, 32'h40);
    chk("R3 equal to running blocks", {31'b0, irq}, 32'd0);

    // R5: nothing qualifies
    reg_read(8'h0C, d);
    chk("R5 spurious", d, 32'd1023);
    chk("R5 no pulse", {31'b0, ack_pulse}, 32'd0);
    reg_read(8'h14, d); chk("R5 running unchanged", d, 32'h40);

    // R9: nested claim
    set_cand(1'b1, 10'd7, 8'h10);
    @(negedge clk);
    chk("R9 preempt irq", {31'b0, irq}, 32'd1);
    reg_read(8'h0C, d); chk("R9 nested ack", d, 32'd7);
    reg_read(8'h14, d); chk("R9 nested running", d, 32'h10);

    // R8: mismatched completion
    reg_write(8'h10, 32'd45);
    chk("R8 mismatch no pulse", {31'b0, eoi_pulse}, 32'd0);
    reg_read(8'h14, d); chk("R8 running kept", d, 32'h10);
    reg_write(8'h10, 32'h0000_0407);
    chk("R8 upper bits no pulse", {31'b0, eoi_pulse}, 32'd0);

    // R7: unwind
    reg_write(8'h10, 32'd7);
    chk("R7 eoi pulse", {31'b0, eoi_pulse}, 32'd1);
    chk("R7 eoi id", {22'b0, eoi_id}, 32'd7);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, eoi_pulse}, 32'd0);
    reg_read(8'h14, d); chk("R7 running restored", d, 32'h40);
    reg_write(8'h10, 32'd45);
    chk("R7 second eoi", {22'b0, eoi_id}, 32'd45);
    reg_read(8'h14, d); chk("R7 running idle", d, 32'h0FF);
    reg_write(8'h10, 32'd45);
    chk("R8 stray eoi", {31'b0, eoi_pulse}, 32'd0);

    // R9: full stack
    for (int k = 0; k < 4; k++) begin
      set_cand(1'b1, 10'(k + 1), 8'(8'h50 - 8'(k * 16)));
      reg_read(8'h0C, d);
      chk($sformatf("R9 fill %0d", k), d, 32'(k + 1));
    end
    set_cand(1'b1, 10'd9, 8'h05);
    @(negedge clk);
    chk("R9 full blocks irq", {31'b0, irq}, 32'd0);
    reg_read(8'h0C, d); chk("R9 full ack spurious", d, 32'd1023);
    for (int k = 4; k >= 1; k--) begin
      reg_write(8'h10, 32'(k));
      chk($sformatf("R9 unwind %0d", k), {22'b0, eoi_id}, 32'(k));
    end
    reg_read(8'h14, d); chk("R9 stack empty", d, 32'h0FF);

    // R6: reserved id not claimable
    set_cand(1'b1, 10'd1022, 8'h01);
    reg_read(8'h0C, d); chk("R6 reserved ack", d, 32'd1023);
    chk("R6 reserved no pulse", {31'b0, ack_pulse}, 32'd0);

    // R10: read-only status
    set_cand(1'b1, 10'd99, 8'h80);
    reg_read(8'h18, d); chk("R10 highest pending", d, 32'd99);
    set_cand(1'b1, 10'd1021, 8'h80);
    reg_read(8'h18, d); chk("R10 reserved pending", d, 32'd1023);
    set_cand(1'b0, 10'd99, 8'h80);
    reg_read(8'h18, d); chk("R10 none pending", d, 32'd1023);
    reg_write(8'h14, 32'd0);
    reg_read(8'h14, d); chk("R10 running read-only", d, 32'h0FF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule